// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the multiplexed external-memory bus timing for a small 8-bit controller core. It runs on the oscillator clock. Each machine cycle is cut into two halves of `HALF_LEN` clocks, for a total of 12 clocks at the defaults. Once per machine cycle the core hands over one request: an internal cycle with no external code fetch, an external code fetch, or an external data read or write. A data access uses either a 16-bit or an 8-bit pointer.

From the request, the sequencer drives four strobes: the address latch pulse, the active-low code read strobe, and the active-low data read and write strobes. It also drives the low address byte, time-multiplexed with data, on the low port. The high port carries either an address byte or the core's port-2 register. Bytes read back from the bus are returned to the core with a one-clock valid pulse.

The latch pulse can be restricted to data transfers only. A level-sensitive reset pin is filtered, so that it takes effect only after being held for two whole machine cycles.

Top module: `ext_bus_seq`

## Requirements
- R1: With `ale_dis_i` low, in internal (`kind` 00) and code-fetch (`kind` 01) cycles, `ale_o` is a one-clock pulse at local phase 0 of each half. This gives one pulse every 6 clocks.
- R2: In a data cycle (`kind` 10 read, 11 write), `ale_o` pulses only at phase 0. The pulse of the second half is omitted.
- R3: With `ale_dis_i` high, `ale_o` stays low in internal and code-fetch cycles. Data cycles still pulse at phase 0.
- R4: In a code-fetch cycle, `psen_n_o` is low at local phases 2 to 4 of both halves. It stays high through internal and data cycles.
- R5: `rd_n_o` (read cycles only) and `wr_n_o` (write cycles only) are low at phases 3 to 10. They are never low together and never low while `ale_o` is high.
- R6: `p0_oe_o` is high with the low address byte at local phases 0 to 1 of a fetch half, and at phases 0 to 1 of a data cycle. A write then drives the write data at phases 2 to 11. A read or fetch releases the port otherwise.
- R7: `p0_i` is sampled on the last clock of each `psen_n_o` or `rd_n_o` low window. The byte appears on `rdata_o`, with `rvalid_o` high for exactly the following clock.
- R8: `p2_o` carries the high byte of the fetch address in a code fetch. The fetch address is `addr` in the first half and `addr+1` in the second. In a 16-bit data access (`wide` = 1) it carries `addr[15:8]`. Otherwise it carries `p2_reg_i`.
- R9: `kind_i`, `wide_i`, `addr_i` and `wdata_i` are sampled only on the edge that ends phase 11, while `req_take_o` is high. Values at other times have no effect.
- R10: After `ext_rst_i` has been high for 24 consecutive clocks, all strobes are inactive (`ale_o` low, the others high), the low port is released and `req_take_o` is low. A shorter pulse has no effect.
- R11: After `ext_rst_i` falls following a recognised reset, the sequencer restarts at phase 0 with an internal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | Level reset pin, filtered |
| ale_dis_i | input | 1 | Restrict latch pulse to data cycles |
| kind_i | input | 2 | Request kind: 00 internal, 01 code fetch, 10 data read, 11 data write |
| wide_i | input | 1 | Data access uses a 16-bit pointer |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| p2_reg_i | input | 8 | Port-2 register value |
| p0_i | input | 8 | Low port input |
| ale_o | output | 1 | Address latch pulse |
| psen_n_o | output | 1 | Code read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p0_o | output | 8 | Low port address/data out |
| p0_oe_o | output | 1 | Low port output enable |
| p2_o | output | 8 | High port output |
| rdata_o | output | 8 | Captured read byte |
| rvalid_o | output | 1 | Read byte valid, one clock |
| req_take_o | output | 1 | Request sampled at end of this clock |

## Verification
Several properties are checked on every clock:
- the two data strobes are exclusive, and neither is low while the latch pulse is high;
- the latch pulse never lasts two clocks;
- a read valid always follows a low code or data read strobe;
- the filtered reset always keeps the bus quiet and returns the phase to zero.

Other behaviour can only be shown by the bench scenarios:
- the exact phase placement of each strobe;
- the skipped latch and code-read pulses in data cycles;
- the `addr+1` carry into the high port;
- gating by the disable bit;
- the port-2 register substitution;
- rejection of a reset pulse shorter than 24 clocks.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_CODE = 2'b01,
    K_RD   = 2'b10,
    K_WR   = 2'b11
  } kind_e;
endpackage

// File: rtl/ebs_reset_filter.sv
module ebs_reset_filter #(
  parameter int HOLD = 24,
  localparam int CW = $clog2(HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!pin_i)                cnt_q <= '0;
    else if (cnt_q != CW'(HOLD))    cnt_q <= cnt_q + 1'b1;
  end

  assign active_o = (cnt_q == CW'(HOLD));

  // R10: recognised reset needs the pin high on the previous edge
  assert_filter_pin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> $past(pin_i));
endmodule

// File: rtl/ebs_phase_gen.sv
module ebs_phase_gen #(
  parameter int HALF_LEN = 6,
  localparam int CYC_LEN = 2 * HALF_LEN,
  localparam int PW = $clog2(CYC_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [PW-1:0] phase_o,
  output logic [PW-1:0] lphase_o,
  output logic          half_o,
  output logic          last_o
);
  logic [PW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               q <= '0;
    else if (clr_i || q == PW'(CYC_LEN - 1))   q <= '0;
    else                                       q <= q + 1'b1;
  end

  assign phase_o  = q;
  assign half_o   = (q >= PW'(HALF_LEN));
  assign lphase_o = half_o ? q - PW'(HALF_LEN) : q;
  assign last_o   = (q == PW'(CYC_LEN - 1));

  assert_phase_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_o == '0);
  assert_phase_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < PW'(CYC_LEN));
endmodule

// File: rtl/ebs_strobe_decode.sv
module ebs_strobe_decode
  import ebs_pkg::*;
#(
  parameter int HALF_LEN = 6,
  localparam int CYC_LEN = 2 * HALF_LEN,
  localparam int PW = $clog2(CYC_LEN),
  localparam int ADDR_LEN = 2,
  localparam int PSEN_FIRST = 2,
  localparam int PSEN_LAST = HALF_LEN - 2,
  localparam int STB_FIRST = 3,
  localparam int STB_LAST = CYC_LEN - 2
) (
  input  logic [PW-1:0] phase_i,
  input  logic [PW-1:0] lphase_i,
  input  kind_e         kind_i,
  input  logic          ale_dis_i,
  input  logic          hold_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          addr_sel_o,
  output logic          data_sel_o,
  output logic          cap_o
);
  logic code, rd, wr, dat, stb_win;

  always_comb begin
    code    = (kind_i == K_CODE);
    rd      = (kind_i == K_RD);
    wr      = (kind_i == K_WR);
    dat     = rd | wr;
    stb_win = (phase_i >= PW'(STB_FIRST)) && (phase_i <= PW'(STB_LAST));
    ale_o      = 1'b0;
    psen_n_o   = 1'b1;
    rd_n_o     = 1'b1;
    wr_n_o     = 1'b1;
    addr_sel_o = 1'b0;
    data_sel_o = 1'b0;
    cap_o      = 1'b0;
    if (!hold_i) begin
      // data cycles keep only the first latch pulse, even when gated
      ale_o      = dat ? (phase_i == '0) : (!ale_dis_i && lphase_i == '0);
      psen_n_o   = !(code && lphase_i >= PW'(PSEN_FIRST) && lphase_i <= PW'(PSEN_LAST));
      rd_n_o     = !(rd && stb_win);
      wr_n_o     = !(wr && stb_win);
      addr_sel_o = code ? (lphase_i < PW'(ADDR_LEN)) : (dat && phase_i < PW'(ADDR_LEN));
      data_sel_o = wr && (phase_i >= PW'(ADDR_LEN));
      cap_o      = code ? (lphase_i == PW'(PSEN_LAST)) : (rd && phase_i == PW'(STB_LAST));
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int HALF_LEN = 6,
  parameter int RST_CYCLES = 2,
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int CYC_LEN = 2 * HALF_LEN,
  localparam int PW = $clog2(CYC_LEN),
  localparam int HW = AW - DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_rst_i,
  input  logic          ale_dis_i,
  input  logic [1:0]    kind_i,
  input  logic          wide_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [HW-1:0] p2_reg_i,
  input  logic [DW-1:0] p0_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic [DW-1:0] p0_o,
  output logic          p0_oe_o,
  output logic [HW-1:0] p2_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          req_take_o
);
  logic          rst_act;
  logic [PW-1:0] phase, lphase;
  logic          half, last;
  kind_e         kind_q, kind_eff;
  logic          wide_q;
  logic [AW-1:0] addr_q, fetch_addr;
  logic [DW-1:0] wdata_q;
  logic          addr_sel, data_sel, cap;

  ebs_reset_filter #(.HOLD(RST_CYCLES * CYC_LEN)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_rst_i), .active_o(rst_act)
  );

  ebs_phase_gen #(.HALF_LEN(HALF_LEN)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rst_act),
    .phase_o(phase), .lphase_o(lphase), .half_o(half), .last_o(last)
  );

  assign req_take_o = last && !rst_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= K_NONE;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (rst_act) begin
      kind_q  <= K_NONE;
    end else if (last) begin
      kind_q  <= kind_e'(kind_i);
      wide_q  <= wide_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign kind_eff = rst_act ? K_NONE : kind_q;

  ebs_strobe_decode #(.HALF_LEN(HALF_LEN)) u_dec (
    .phase_i(phase), .lphase_i(lphase), .kind_i(kind_eff), .ale_dis_i(ale_dis_i),
    .hold_i(rst_act), .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .addr_sel_o(addr_sel), .data_sel_o(data_sel), .cap_o(cap)
  );

  // second fetch half reads the next byte
  assign fetch_addr = addr_q + AW'(half);

  always_comb begin
    p0_o = '0;
    if (addr_sel)      p0_o = (kind_eff == K_CODE) ? fetch_addr[DW-1:0] : addr_q[DW-1:0];
    else if (data_sel) p0_o = wdata_q;
    p0_oe_o = addr_sel | data_sel;
    if (kind_eff == K_CODE)               p2_o = fetch_addr[AW-1:DW];
    else if (kind_eff[1] && wide_q)       p2_o = addr_q[AW-1:DW];
    else                                  p2_o = p2_reg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= cap;
      if (cap) rdata_o <= p0_i;
    end
  end

  assert_rd_wr_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  assert_stb_not_ale_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> !ale_o);
  assert_stb_after_ale_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_n_o) || $fell(wr_n_o)) |-> $past(!ale_o));
  assert_ale_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  assert_rvalid_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(!rd_n_o || !psen_n_o));
  assert_rst_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act |-> (!ale_o && psen_n_o && rd_n_o && wr_n_o && !p0_oe_o && !req_take_o));
endmodule

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, ext_rst, ale_dis, wide;
  logic [1:0] kind;
  logic [15:0] addr;
  logic [7:0] wdata, p2_reg, p0_in;
  logic ale, psen_n, rd_n, wr_n, p0_oe, rvalid, req_take;
  logic [7:0] p0_out, p2_out, rdata;

  ext_bus_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst), .ale_dis_i(ale_dis),
    .kind_i(kind), .wide_i(wide), .addr_i(addr), .wdata_i(wdata),
    .p2_reg_i(p2_reg), .p0_i(p0_in), .ale_o(ale), .psen_n_o(psen_n),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .p0_o(p0_out), .p0_oe_o(p0_oe),
    .p2_o(p2_out), .rdata_o(rdata), .rvalid_o(rvalid), .req_take_o(req_take)
  );

  int n_chk = 0, n_fail = 0;
  bit run_chk = 0, done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model
  int m_cnt, m_ph;
  logic [1:0] m_kind;
  logic m_wide, m_rvalid;
  logic [15:0] m_addr;
  logic [7:0] m_wdata, m_rdata;

  function automatic bit exp_cap(int ph, logic [1:0] k, bit act);
    return !act && ((k == 2'b01 && (ph % 6) == 4) || (k == 2'b10 && ph == 10));
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    bit act;
    if (!rst_ni) begin
      m_cnt = 0; m_ph = 0; m_kind = 0; m_wide = 0; m_addr = 0;
      m_wdata = 0; m_rdata = 0; m_rvalid = 0;
    end else begin
      act = (m_cnt == 24);
      m_rvalid <= exp_cap(m_ph, m_kind, act);
      if (exp_cap(m_ph, m_kind, act)) m_rdata <= p0_in;
      m_cnt <= !ext_rst ? 0 : (m_cnt == 24 ? 24 : m_cnt + 1);
      if (act) begin
        m_ph <= 0; m_kind <= 0;
      end else if (m_ph == 11) begin
        m_ph <= 0; m_kind <= kind; m_wide <= wide; m_addr <= addr; m_wdata <= wdata;
      end else m_ph <= m_ph + 1;
    end
  end

  always @(negedge clk) begin
    bit act, code, rd, wr, dat, e_ale, e_oe;
    int lp;
    logic [15:0] fa;
    logic [7:0] e_p0, e_p2;
    string t_ale;
    if (run_chk) begin
      act = (m_cnt == 24);
      lp = m_ph % 6;
      code = !act && m_kind == 2'b01;
      rd = !act && m_kind == 2'b10;
      wr = !act && m_kind == 2'b11;
      dat = rd || wr;
      e_ale = act ? 1'b0 : dat ? (m_ph == 0) : (!ale_dis && lp == 0);
      t_ale = act ? "R10" : dat ? "R2" : ale_dis ? "R3" : "R1";
      chk(t_ale, "ale", ale, e_ale);
      chk("R4", "psen_n", psen_n, !(code && lp >= 2 && lp <= 4));
      chk("R5", "rd_n", rd_n, !(rd && m_ph >= 3 && m_ph <= 10));
      chk("R5", "wr_n", wr_n, !(wr && m_ph >= 3 && m_ph <= 10));
      e_oe = code ? (lp < 2) : rd ? (m_ph < 2) : wr;
      chk(act ? "R10" : "R6", "p0_oe", p0_oe, e_oe);
      fa = m_addr + ((m_ph >= 6) ? 16'd1 : 16'd0);
      e_p0 = code ? fa[7:0] : (m_ph < 2 ? m_addr[7:0] : m_wdata);
      if (e_oe) chk("R6", "p0", p0_out, e_p0);
      e_p2 = code ? fa[15:8] : (dat && m_wide) ? m_addr[15:8] : p2_reg;
      chk("R8", "p2", p2_out, e_p2);
      chk("R7", "rvalid", rvalid, m_rvalid);
      if (m_rvalid) chk("R7", "rdata", rdata, m_rdata);
      chk("R9", "req_take", req_take, !act && m_ph == 11);
    end
  end

  task automatic rand_drive(bit dis_sticky);
    kind = 2'($urandom_range(0, 3));
    wide = 1'($urandom_range(0, 1));
    addr = 16'($urandom);
    wdata = 8'($urandom);
    p2_reg = 8'($urandom);
    p0_in = 8'($urandom);
    if (!dis_sticky && $urandom_range(0, 15) == 0) ale_dis = ~ale_dis;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 0; ext_rst = 0; ale_dis = 0; kind = 0; wide = 0;
    addr = 0; wdata = 0; p2_reg = 8'h5A; p0_in = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    run_chk = 1;
    @(negedge clk);
    // reset state: phase 0, internal cycle
    chk("R1", "ale_reset", ale, 1'b1);
    chk("R4", "psen_reset", psen_n, 1'b1);
    chk("R8", "p2_reset", p2_out, 8'h5A);
    // directed: code fetch with carry into high byte
    @(posedge clk); #1;
    kind = 2'b01; addr = 16'h12FF; p0_in = 8'hC3;
    repeat (36) @(posedge clk);
    #1;
    // R8 directed: 8-bit data read uses port-2 register
    kind = 2'b10; wide = 0; addr = 16'hABCD; p2_reg = 8'h77;
    repeat (36) @(posedge clk);
    #1;
    // random, latch pulse free running
    for (int i = 0; i < 1500; i++) begin
      @(posedge clk); #1; rand_drive(0);
    end
    // random with pulse gated (R3)
    ale_dis = 1;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1; rand_drive(1);
    end
    ale_dis = 0;
    // R10: pulse of 20 clocks must be ignored
    ext_rst = 1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; rand_drive(1);
    end
    ext_rst = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1; rand_drive(1);
    end
    // R10: long pulse recognised
    ext_rst = 1;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1; rand_drive(1);
    end
    @(negedge clk);
    chk("R10", "ale_in_rst", ale, 1'b0);
    chk("R10", "rd_in_rst", rd_n, 1'b1);
    @(posedge clk); #1;
    ext_rst = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "ale_restart", ale, 1'b1);
    chk("R11", "psen_restart", psen_n, 1'b1);
    chk("R11", "take_restart", req_take, 1'b0);
    for (int i = 0; i < 1200; i++) begin
      @(posedge clk); #1; rand_drive(0);
    end
    run_chk = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule